// File: doc/BRIEF.md
# System Reset Generator with Qualified Manual Reset

This block drives the active-low system reset of a supervisor. It gathers per-channel undervoltage flags and an active-low manual reset request and keeps the reset asserted while any of them is present. Once every cause has cleared, it holds the reset for one further timeout before it releases. A new cause that arrives during that timeout cancels it. The count then starts again from zero after the last cause clears.

The manual reset request comes from a pad or from a looped-back watchdog fault. It passes through a synchronizer and a glitch filter. It must then stay low for a minimum qualification time before it counts as a cause, so that short pulses cannot reset the system. A separate active-low margin input freezes the reset state and the timeout count while it is low. This lets supplies be moved during test without disturbing the system, and margin wins over a concurrent manual reset.

The block also drives a reset-active level that a watchdog uses to keep its timer cleared. All time constants are parameters given in clock cycles.

Top module: `sysrst_gen`

## Requirements
- R1: Any set bit of `uv_flag` asserts the reset. With margin inactive, `rst_out_n` is low after the third rising clock edge following the change, counting two synchronizer stages and one output register. An all-zero `uv_flag` never asserts it.
- R2: While `rst` is high, and immediately after it, `rst_out_n` is 0 and `rst_active` is 1. With all inputs idle when `rst` falls, `rst_out_n` stays 0 for TMO_CYC-1 edges and rises on edge TMO_CYC.
- R3: After the last undervoltage flag clears, `rst_out_n` stays low for TMO_CYC+1 edges and rises on edge TMO_CYC+2.
- R4: A cause that appears during the timeout, even for a single cycle, cancels the timeout. Release then follows the R3 timing, measured from the moment that cause clears.
- R5: A manual reset pulse low for fewer than QUAL_CYC cycles is ignored, and so is a single-cycle glitch. `rst_out_n` stays high.
- R6: A manual reset held low for QUAL_CYC cycles or longer asserts the reset at edge QUAL_CYC+5 after the falling input, with FILT_CYC = 2. When `mr_n` returns high, the release comes at edge TMO_CYC+5.
- R7: Three edges after `margin_n` goes low, the reset output and the timeout count hold their current values for as long as margin stays low. This holds whether the output is asserted or released. Counting resumes once margin is high again.
- R8: While margin is active, a qualified manual reset has no effect. If manual reset is still low when margin returns high, reset asserts at the third edge after `margin_n` rises.
- R9: `rst_active` is always the inverse of `rst_out_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| uv_flag | input | NCH | Per-channel undervoltage flags, 1 = below threshold |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| margin_n | input | 1 | Margin freeze, active low, asynchronous |
| rst_out_n | output | 1 | System reset, active low, registered |
| rst_active | output | 1 | High while the reset is asserted, registered |

## Verification
The hardest case to reach is a reset frozen while asserted, partway through its timeout. To get there, the stimulus sets a cause under margin, lifts margin so the reset asserts, and clears every cause. It then lowers margin again a few cycles into the count and waits well past the timeout. Manual reset pulses of exactly QUAL_CYC-1 and QUAL_CYC cycles pin the qualifier boundary. A one-cycle flag pulse in the middle of a timeout shows that the count restarts rather than merely pausing.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

  // width of a counter that must hold values 0 .. n-1
  function automatic int ctr_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int            W      = 1,
  parameter int            STAGES = 2,
  parameter logic [W-1:0]  INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{INIT}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sysrst_mr_qual.sv
module sysrst_mr_qual #(
  parameter int FILT_CYC = 4,
  parameter int QUAL_CYC = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic mr_s,
  output logic mr_f,
  output logic mr_hit
);

  localparam int FW = sysrst_pkg::ctr_w(FILT_CYC);
  localparam int QW = sysrst_pkg::ctr_w(QUAL_CYC);
  localparam logic [FW-1:0] F_LAST = FW'(FILT_CYC - 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);

  logic [FW-1:0] fcnt_q;
  logic [QW-1:0] qcnt_q;

  // debounce: the filtered level follows only after FILT_CYC equal samples
  always_ff @(posedge clk) begin
    if (rst) begin
      mr_f   <= 1'b1;
      fcnt_q <= '0;
    end else if (mr_s == mr_f) begin
      fcnt_q <= '0;
    end else if (fcnt_q == F_LAST) begin
      mr_f   <= mr_s;
      fcnt_q <= '0;
    end else begin
      fcnt_q <= fcnt_q + 1'b1;
    end
  end

  // minimum-low qualifier on the filtered level
  always_ff @(posedge clk) begin
    if (rst || mr_f) begin
      qcnt_q <= '0;
      mr_hit <= 1'b0;
    end else if (!mr_hit) begin
      if (qcnt_q == Q_LAST) mr_hit <= 1'b1;
      else                  qcnt_q <= qcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sysrst_hold_timer.sv
module sysrst_hold_timer #(
  parameter int TMO_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  input  logic hold,
  output logic act_q,
  output logic out_n_q
);

  localparam int CW = sysrst_pkg::ctr_w(TMO_CYC);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b1;
      out_n_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!hold) begin
      if (cause) begin
        act_q   <= 1'b1;
        out_n_q <= 1'b0;
        cnt_q   <= '0;
      end else if (act_q) begin
        if (cnt_q == LAST) begin
          act_q   <= 1'b0;
          out_n_q <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sysrst_gen.sv
module sysrst_gen #(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4,
  parameter int QUAL_CYC    = 125,
  parameter int TMO_CYC     = 25_000_000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] uv_flag,
  input  logic           mr_n,
  input  logic           margin_n,
  output logic           rst_out_n,
  output logic           rst_active
);

  logic [NCH-1:0] uv_s;
  logic [1:0]     ctl_s;
  logic           mr_f;
  logic           mr_hit;
  logic           cause;
  logic           frz;

  sysrst_sync #(.W(NCH), .STAGES(SYNC_STAGES), .INIT('0)) u_uv_sync (
    .clk(clk), .rst(rst), .d(uv_flag), .q(uv_s)
  );

  // bit 1 = manual reset, bit 0 = margin; both idle high
  sysrst_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({mr_n, margin_n}), .q(ctl_s)
  );

  sysrst_mr_qual #(.FILT_CYC(FILT_CYC), .QUAL_CYC(QUAL_CYC)) u_mr (
    .clk(clk), .rst(rst), .mr_s(ctl_s[1]), .mr_f(mr_f), .mr_hit(mr_hit)
  );

  assign cause = (|uv_s) | mr_hit;
  assign frz   = ~ctl_s[0];

  sysrst_hold_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst(rst), .cause(cause), .hold(frz),
    .act_q(rst_active), .out_n_q(rst_out_n)
  );

endmodule

// File: rtl/sysrst_gen_chk.sv
module sysrst_gen_chk (
  input logic clk,
  input logic rst,
  input logic rst_out_n,
  input logic rst_active,
  input logic cause,
  input logic frz,
  input logic mr_f,
  input logic mr_hit
);

  // R1
  cause_asserts_chk: assert property (@(posedge clk) disable iff (rst)
    (cause && !frz) |=> !rst_out_n);

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    frz |=> $stable(rst_out_n));

  // R3
  clean_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out_n) |-> $past(!cause && !frz));

  // R5
  qual_low_chk: assert property (@(posedge clk) disable iff (rst)
    mr_hit |-> $past(!mr_f));

  // R9
  active_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    rst_active != rst_out_n);

  // R2
  por_state_chk: assert property (@(posedge clk)
    rst |=> (!rst_out_n && rst_active));

endmodule

bind sysrst_gen sysrst_gen_chk u_chk (
  .clk(clk), .rst(rst), .rst_out_n(rst_out_n), .rst_active(rst_active),
  .cause(cause), .frz(frz), .mr_f(mr_f), .mr_hit(mr_hit)
);

// File: tb/sysrst_gen_test.sv
module sysrst_gen_test;

  localparam int NCH = 8;
  localparam int Q   = 8;
  localparam int T   = 40;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] uv_flag = '0;
  logic           mr_n = 1'b1;
  logic           margin_n = 1'b1;
  logic           rst_out_n;
  logic           rst_active;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sysrst_gen #(.NCH(NCH), .SYNC_STAGES(2), .FILT_CYC(2), .QUAL_CYC(Q), .TMO_CYC(T)) uut (
    .clk(clk), .rst(rst), .uv_flag(uv_flag), .mr_n(mr_n), .margin_n(margin_n),
    .rst_out_n(rst_out_n), .rst_active(rst_active)
  );

  // [8:1] flag pattern, [0] expected rst_out_n three edges later
  localparam logic [8:0] VEC [8] = '{
    {8'h00, 1'b1}, {8'h01, 1'b0}, {8'h80, 1'b0}, {8'h10, 1'b0},
    {8'hA5, 1'b0}, {8'h00, 1'b1}, {8'hFF, 1'b0}, {8'h42, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rst_out_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // observe n edges, expect the output to stay released throughout
  task automatic stay_high(input int n, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      edges(1);
      if (rst_out_n !== 1'b1) bad++;
    end
    chk((bad == 0) ? 1'b1 : 1'b0, 1'b1, req);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R2: reset state and power-up release
    edges(2);
    chk(rst_out_n, 1'b0, "R2 in reset");
    chk(rst_active, 1'b1, "R2 active in reset");
    @(negedge clk) rst = 1'b0;
    edges(T - 1);
    chk(rst_out_n, 1'b0, "R2 before power-up release");
    edges(1);
    chk(rst_out_n, 1'b1, "R2 power-up release");
    chk(rst_active, 1'b0, "R9 active low when released");

    // R1 / R3: table of undervoltage patterns
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) uv_flag = VEC[i][8:1];
      edges(3);
      chk(rst_out_n, VEC[i][0], "R1 pattern");
      @(negedge clk) uv_flag = '0;
      if (VEC[i][0] == 1'b0) begin
        edges(T + 1);
        chk(rst_out_n, 1'b0, "R3 before release");
        edges(1);
        chk(rst_out_n, 1'b1, "R3 release edge");
      end else begin
        stay_high(5, "R1 zero pattern");
      end
    end

    // R4: single-cycle cause restarts the timeout
    @(negedge clk) uv_flag = 8'h04;
    edges(3);
    chk(rst_out_n, 1'b0, "R4 asserted");
    @(negedge clk) uv_flag = '0;
    edges(10);
    @(negedge clk) uv_flag = 8'h08;
    @(negedge clk) uv_flag = '0;
    edges(T + 1);
    chk(rst_out_n, 1'b0, "R4 restarted count");
    edges(1);
    chk(rst_out_n, 1'b1, "R4 release after restart");

    // R5: glitch and sub-threshold pulse ignored
    @(negedge clk) mr_n = 1'b0;
    @(negedge clk) mr_n = 1'b1;
    stay_high(20, "R5 glitch");
    @(negedge clk) mr_n = 1'b0;
    repeat (Q - 1) @(negedge clk);
    mr_n = 1'b1;
    stay_high(20, "R5 short pulse");

    // R6: pulse of exactly QUAL_CYC
    @(negedge clk) mr_n = 1'b0;
    repeat (Q) @(negedge clk);
    mr_n = 1'b1;
    edges(4);
    chk(rst_out_n, 1'b1, "R6 before assert");
    edges(1);
    chk(rst_out_n, 1'b0, "R6 boundary pulse asserts");
    edges(T - 1);
    chk(rst_out_n, 1'b0, "R6 boundary before release");
    edges(1);
    chk(rst_out_n, 1'b1, "R6 boundary release");

    // R6: held manual reset, release timing
    @(negedge clk) mr_n = 1'b0;
    edges(Q + 8);
    chk(rst_out_n, 1'b0, "R6 held asserts");
    chk(rst_active, 1'b1, "R9 active high when asserted");
    @(negedge clk) mr_n = 1'b1;
    edges(T + 4);
    chk(rst_out_n, 1'b0, "R6 before release");
    edges(1);
    chk(rst_out_n, 1'b1, "R6 release");

    // R7 / R8: margin freezes released state and overrides manual reset
    @(negedge clk) margin_n = 1'b0;
    edges(3);
    @(negedge clk) uv_flag = 8'h01;
    edges(6);
    chk(rst_out_n, 1'b1, "R7 frozen released");
    @(negedge clk) mr_n = 1'b0;
    edges(Q + 8);
    chk(rst_out_n, 1'b1, "R8 margin overrides manual reset");
    @(negedge clk) margin_n = 1'b1;
    edges(2);
    chk(rst_out_n, 1'b1, "R8 before margin lift takes effect");
    edges(1);
    chk(rst_out_n, 1'b0, "R8 asserts after margin lifts");

    // R7: freeze while asserted and counting
    @(negedge clk) begin uv_flag = '0; mr_n = 1'b1; end
    edges(8);
    @(negedge clk) margin_n = 1'b0;
    edges(T + 10);
    chk(rst_out_n, 1'b0, "R7 frozen asserted");
    @(negedge clk) margin_n = 1'b1;
    edges(T + 5);
    chk(rst_out_n, 1'b1, "R7 count resumes");
    chk(rst_active, 1'b0, "R9 active mirrors output");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule